// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Control

This block holds one 64-bit control register shared by up to four CPUs. A CPU writes it to send inter-processor interrupts (IPIs) to other CPUs, to acknowledge IPIs aimed at itself, and to acknowledge the periodic timer interrupt. Each access carries the ID of the issuing CPU. A read returns the current interrupt status, and the low two bits of the returned word hold the ID of the reader.

IPIs are counted per CPU in a small saturating counter. The IPI output of a CPU stays high until every outstanding request has been acknowledged. The timer interrupt is a single latch per CPU. An external tick sets it on every CPU where it is clear, and a write acknowledge clears it. Only full 64-bit accesses are legal. Narrow accesses, and writes that hit no known field, raise a one-cycle error pulse.

Top module: `ipi_tmr_ctrl`

## Requirements
- R1: A full write with bit 12+i set adds one to the IPI count of CPU i. The IPI output of that CPU is high from the clock edge that takes the write for as long as the count is nonzero.
- R2: A full write with bit 8+i set takes one from a nonzero IPI count of CPU i. The IPI output drops only on the write that brings the count to zero. An acknowledge at count zero has no effect.
- R3: When one write sets both the request bit and the acknowledge bit of the same CPU, the increment is applied before the decrement, so a count below 15 ends unchanged.
- R4: The IPI count is 4 bits wide and holds at 15 when further requests arrive. From 15, exactly 15 acknowledges are needed to drop the output.
- R5: A high pulse on the tick input sets the timer interrupt of every CPU whose timer interrupt is low.
- R6: A full write with bit 4+i set clears the timer interrupt of CPU i if that interrupt is high. If the acknowledge and a tick arrive in the same cycle, an asserted interrupt is cleared and a clear one is set.
- R7: A full read gives, one cycle later on the read data, the word with bits 11:8 holding the per-CPU IPI pending flags, bits 7:4 holding the timer interrupt flags, and bits 1:0 holding the reader's CPU ID. All other bits are zero.
- R8: A full write that sets no bit in 15:4 and has bit 28 clear raises the error output for one cycle. A write with only bit 28 set is accepted and changes nothing.
- R9: An access with the full-width flag low changes no state and raises the error output for the cycle after it.
- R10: Synchronous reset clears all counts, all interrupt outputs, the read data and the error output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| full_acc | input | 1 | High when the access is 64 bits wide |
| cpu_id | input | 2 | ID of the CPU issuing the access |
| wdata | input | 64 | Write data |
| tick | input | 1 | Periodic timer pulse |
| rdata | output | 64 | Registered read data |
| acc_err | output | 1 | Registered error pulse for a bad access |
| ipi_irq | output | NCPU | Per-CPU IPI interrupt |
| tmr_irq | output | NCPU | Per-CPU timer interrupt |

## Verification
The counting is tried with repeated requests to one CPU, with requests that target two CPUs in one write, and with a request and an acknowledge in the same write. These cases separate a true counter from a plain set/clear flag and show the order in which a combined write is applied. The timer path is tried with a broadcast tick, a single-CPU acknowledge followed by a new tick, an acknowledge of a clear interrupt, and an acknowledge that lands in the same cycle as a tick. Reads from different CPU IDs check the status layout. Empty writes, bit-28-only writes and narrow accesses check the error rules.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
  localparam int MAX_CPU     = 4;
  localparam int FIELD_W     = 4;
  localparam int TACK_LSB    = 4;
  localparam int IACK_LSB    = 8;
  localparam int IREQ_LSB    = 12;
  localparam int NOP_BIT     = 28;
  localparam int WORD_W      = 64;

  typedef struct packed {
    logic [FIELD_W-1:0] ipi_req;
    logic [FIELD_W-1:0] ipi_ack;
    logic [FIELD_W-1:0] tmr_ack;
    logic               known;
  } wr_fields_t;
endpackage

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode
  import ipi_tmr_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  output wr_fields_t        fields
);
  always_comb begin
    fields.ipi_req = wdata[IREQ_LSB +: FIELD_W];
    fields.ipi_ack = wdata[IACK_LSB +: FIELD_W];
    fields.tmr_ack = wdata[TACK_LSB +: FIELD_W];
    fields.known   = (|wdata[IREQ_LSB+FIELD_W-1:TACK_LSB]) | wdata[NOP_BIT];
  end
endmodule

// File: rtl/ipi_counter.sv
module ipi_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             ack,
  output logic             irq,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] after_req;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    after_req = (req && cnt != CMAX) ? cnt + 1'b1 : cnt;
    nxt       = (ack && after_req != '0) ? after_req - 1'b1 : after_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      cnt <= nxt;
      irq <= (nxt != '0);
    end
  end

  // R1
  ipi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    req && !ack && cnt == '0 |=> irq && cnt == 1);
  // R2
  ipi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ack && !req && cnt > 1 |=> irq && cnt == $past(cnt) - 1'b1);
  // R2
  ipi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ack && !req && cnt == 1 |=> !irq);
  // R3
  pair_even_chk: assert property (@(posedge clk) disable iff (rst)
    req && ack && cnt != CMAX |=> cnt == $past(cnt));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    req && !ack && cnt == CMAX |=> cnt == CMAX);
endmodule

// File: rtl/tmr_latch.sv
module tmr_latch (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ack,
  output logic irq
);
  logic nxt;

  always_comb begin
    if (irq) nxt = !ack;
    else     nxt = tick;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= nxt;
  end

  // R5
  tick_set_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !irq |=> irq);
  // R6
  tmr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !ack |=> irq);
  // R6
  tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq && ack |=> !irq);
endmodule

// File: rtl/ipi_tmr_ctrl.sv
module ipi_tmr_ctrl
  import ipi_tmr_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              full_acc,
  input  logic [1:0]        cpu_id,
  input  logic [WORD_W-1:0] wdata,
  input  logic              tick,
  output logic [WORD_W-1:0] rdata,
  output logic              acc_err,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  wr_fields_t          fld;
  logic                wr_ok;
  logic                bad_acc;
  logic [FIELD_W-1:0]  ipi_view;
  logic [FIELD_W-1:0]  tmr_view;
  logic [WORD_W-1:0]   rd_word;

  initial begin
    ncpu_range_chk: assert (NCPU >= 1 && NCPU <= MAX_CPU);
  end

  ipi_tmr_decode u_dec (
    .wdata  (wdata),
    .fields (fld)
  );

  assign wr_ok = wr_en && full_acc;

  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      logic [CNT_W-1:0] cnt_unused;
      ipi_counter #(.CNT_W(CNT_W)) u_ipi (
        .clk (clk),
        .rst (rst),
        .req (wr_ok && fld.ipi_req[i]),
        .ack (wr_ok && fld.ipi_ack[i]),
        .irq (ipi_irq[i]),
        .cnt (cnt_unused)
      );
      tmr_latch u_tmr (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ack  (wr_ok && fld.tmr_ack[i]),
        .irq  (tmr_irq[i])
      );
    end
  endgenerate

  always_comb begin
    ipi_view = '0;
    tmr_view = '0;
    ipi_view[NCPU-1:0] = ipi_irq;
    tmr_view[NCPU-1:0] = tmr_irq;
    rd_word = '0;
    rd_word[IACK_LSB +: FIELD_W] = ipi_view;
    rd_word[TACK_LSB +: FIELD_W] = tmr_view;
    rd_word[1:0] = cpu_id;
    bad_acc = ((wr_en || rd_en) && !full_acc) || (wr_ok && !fld.known);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      acc_err <= bad_acc;
      if (rd_en && full_acc) rdata <= rd_word;
    end
  end

  // R9
  narrow_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) && !full_acc |=> acc_err);
  // R9
  narrow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !full_acc |=> $stable(ipi_irq));
  // R7
  rd_id_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && full_acc |=> rdata[1:0] == $past(cpu_id));
  // R8
  nop_ok_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !rd_en && full_acc && wdata[NOP_BIT] |=> !acc_err);
endmodule

// File: tb/ipi_tmr_ctrl_bench.sv
module ipi_tmr_ctrl_bench;
  localparam int NCPU = 4;

  typedef struct packed {
    logic [1:0]  op;     // 0 idle, 1 write, 2 read, 3 tick
    logic        full;
    logic [31:0] wd;
    logic [1:0]  cpu;
    logic [3:0]  e_ipi;
    logic [3:0]  e_tmr;
    logic        e_err;
    logic        chk_rd;
    logic [15:0] e_rd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b1, 32'h0000_0000, 2'd2, 4'h0, 4'h0, 1'b0, 1'b1, 16'h0002}, // R7
    '{2'd1, 1'b1, 32'h0000_1000, 2'd1, 4'h1, 4'h0, 1'b0, 1'b0, 16'h0000}, // R1
    '{2'd1, 1'b1, 32'h0000_1000, 2'd1, 4'h1, 4'h0, 1'b0, 1'b0, 16'h0000}, // R1
    '{2'd1, 1'b1, 32'h0000_0100, 2'd0, 4'h1, 4'h0, 1'b0, 1'b0, 16'h0000}, // R2
    '{2'd2, 1'b1, 32'h0000_0000, 2'd3, 4'h1, 4'h0, 1'b0, 1'b1, 16'h0103}, // R7
    '{2'd1, 1'b1, 32'h0000_0100, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R2
    '{2'd1, 1'b1, 32'h0000_0100, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R2
    '{2'd1, 1'b1, 32'h0000_A000, 2'd2, 4'hA, 4'h0, 1'b0, 1'b0, 16'h0000}, // R1
    '{2'd1, 1'b1, 32'h0000_2200, 2'd2, 4'hA, 4'h0, 1'b0, 1'b0, 16'h0000}, // R3
    '{2'd1, 1'b1, 32'h0000_0800, 2'd3, 4'h2, 4'h0, 1'b0, 1'b0, 16'h0000}, // R2
    '{2'd1, 1'b1, 32'h0000_0200, 2'd1, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R3
    '{2'd3, 1'b1, 32'h0000_0000, 2'd0, 4'h0, 4'hF, 1'b0, 1'b0, 16'h0000}, // R5
    '{2'd2, 1'b1, 32'h0000_0000, 2'd0, 4'h0, 4'hF, 1'b0, 1'b1, 16'h00F0}, // R7
    '{2'd1, 1'b1, 32'h0000_0020, 2'd1, 4'h0, 4'hD, 1'b0, 1'b0, 16'h0000}, // R6
    '{2'd3, 1'b1, 32'h0000_0000, 2'd0, 4'h0, 4'hF, 1'b0, 1'b0, 16'h0000}, // R5
    '{2'd1, 1'b1, 32'h0000_00F0, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R6
    '{2'd1, 1'b1, 32'h0000_0010, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R6
    '{2'd1, 1'b1, 32'h1000_0000, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}, // R8
    '{2'd1, 1'b1, 32'h0000_0001, 2'd0, 4'h0, 4'h0, 1'b1, 1'b0, 16'h0000}, // R8
    '{2'd1, 1'b0, 32'h0000_1000, 2'd0, 4'h0, 4'h0, 1'b1, 1'b0, 16'h0000}, // R9
    '{2'd2, 1'b0, 32'h0000_0000, 2'd0, 4'h0, 4'h0, 1'b1, 1'b0, 16'h0000}, // R9
    '{2'd0, 1'b1, 32'h0000_0000, 2'd0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000}  // R8
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic            full_acc = 1'b1;
  logic [1:0]      cpu_id = 2'd0;
  logic [63:0]     wdata = '0;
  logic            tick = 1'b0;
  logic [63:0]     rdata;
  logic            acc_err;
  logic [NCPU-1:0] ipi_irq;
  logic [NCPU-1:0] tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_tmr_ctrl #(.NCPU(NCPU), .CNT_W(4)) u_ipi_tmr_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .full_acc(full_acc),
    .cpu_id(cpu_id), .wdata(wdata), .tick(tick), .rdata(rdata),
    .acc_err(acc_err), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic full, input logic [63:0] wd,
                       input logic [1:0] cpu);
    wr_en    = (op == 2'd1);
    rd_en    = (op == 2'd2);
    tick     = (op == 2'd3);
    full_acc = full;
    wdata    = wd;
    cpu_id   = cpu;
  endtask

  task automatic step(input logic [1:0] op, input logic [63:0] wd);
    drive(op, 1'b1, wd, 2'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ipi", 64'(ipi_irq), 64'h0);
    check("R10 tmr", 64'(tmr_irq), 64'h0);
    check("R10 rdata", rdata, 64'h0);
    check("R10 err", 64'(acc_err), 64'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].op, VEC[k].full, 64'(VEC[k].wd), VEC[k].cpu);
      @(negedge clk);
      check($sformatf("vec%0d R1/R2/R3 ipi", k), 64'(ipi_irq), 64'(VEC[k].e_ipi));
      check($sformatf("vec%0d R5/R6 tmr", k), 64'(tmr_irq), 64'(VEC[k].e_tmr));
      check($sformatf("vec%0d R8/R9 err", k), 64'(acc_err), 64'(VEC[k].e_err));
      if (VEC[k].chk_rd)
        check($sformatf("vec%0d R7 rdata", k), rdata, 64'(VEC[k].e_rd));
    end

    // R4 saturation: 17 requests hold the count at 15
    for (int n = 0; n < 17; n++) step(2'd1, 64'h4000);
    drive(2'd2, 1'b1, 64'h0, 2'd1);
    @(negedge clk);
    check("R4 rd pending", rdata, 64'h0401);
    for (int n = 0; n < 14; n++) step(2'd1, 64'h0400);
    check("R4 held after 14 acks", 64'(ipi_irq), 64'h4);
    step(2'd1, 64'h0400);
    check("R4 drop after 15 acks", 64'(ipi_irq), 64'h0);

    // R6 ack and tick in the same cycle
    step(2'd3, 64'h0);
    drive(2'd1, 1'b1, 64'h0010, 2'd0);
    tick = 1'b1;
    @(negedge clk);
    check("R6 ack wins on set cpu", 64'(tmr_irq), 64'hE);
    drive(2'd1, 1'b1, 64'h0010, 2'd0);
    tick = 1'b1;
    @(negedge clk);
    check("R6 tick wins on clear cpu", 64'(tmr_irq), 64'hF);

    // R10 reset mid-run
    step(2'd1, 64'h8000);
    drive(2'd2, 1'b1, 64'h0, 2'd3);
    @(negedge clk);
    drive(2'd0, 1'b1, 64'h0, 2'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 ipi after reset", 64'(ipi_irq), 64'h0);
    check("R10 tmr after reset", 64'(tmr_irq), 64'h0);
    check("R10 rdata after reset", rdata, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule